// File: doc/BRIEF.md
# Network Interrupt Status and Mask Unit

This block gathers the event pulses of an Ethernet controller into one interrupt request. The receiver, transmitter, remote-DMA engine and run/stop logic each raise a single-cycle pulse. The pulse sets a sticky bit in an 8-bit status register. Software clears those bits by writing ones to the status offset. A 7-bit enable register selects which bits may drive the `irq_o` line.

The unit also keeps three 8-bit receive error tallies: frame alignment errors, CRC errors and missed frames. Reading a tally returns its value and clears it. The top bits of the tallies together drive a counter-overflow status bit. The top status bit shows whether the controller is stopped. It is not latched from an event: stop commands and ring overwrites set it, and start commands and packet removal clear it. Software cannot write it.

All register access is plain control: `wr_en_i` and `rd_en_i` share the address bus `addr_i`. `rd_data_o` is combinational in the cycle of the read. A read of a tally clears it at the clock edge that ends that cycle.

Top module: `net_irq_unit`

## Requirements
- R1: After reset the status reads 0x80, the enable register reads 0x00, all three tallies read 0 and `irq_o` is low.
- R2: A pulse sets the status bit at address 0 and the bit stays set until cleared: bit 0 `evt_rx_ok_i`, bit 1 `evt_tx_ok_i`, bit 2 `evt_rx_err_i`, bit 3 `evt_tx_err_i`, bit 4 `evt_ring_ovw_i`, bit 6 `evt_rdma_done_i`.
- R3: Writing address 0 clears each of bits 0–4 and 6 whose data bit is 1 and leaves the bits written as 0 unchanged. An event in the same cycle as its clear leaves the bit set.
- R4: The enable register at address 1 stores bits 0–6 of a write. Its bit 7 always reads 0.
- R5: `irq_o` is high exactly when some bit among status bits 0–6 is set together with its enable bit.
- R6: Status bit 7 is set by `stop_cmd_i` or `evt_ring_ovw_i` and cleared by `start_cmd_i` or `pkt_removed_i`. If set and clear arrive in the same cycle, the set wins. Writes to address 0 never change it.
- R7: Tallies sit at address 2 (frame alignment), 3 (CRC) and 4 (missed). Each counts one per pulse of `inc_align_i`, `inc_crc_i` or `inc_miss_i` and holds at 255.
- R8: A read of a tally returns its value and clears it. An increment in the cycle of that read leaves the tally at 1.
- R9: Status bit 5 is the OR of the three tallies' bit 7. Writes to address 0 do not change it. It can be enabled onto `irq_o` like any other bit.
- R10: Reads of addresses 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_rx_ok_i | input | 1 | Frame received without error |
| evt_tx_ok_i | input | 1 | Frame transmitted without error |
| evt_rx_err_i | input | 1 | Frame received with error |
| evt_tx_err_i | input | 1 | Transmission failed |
| evt_ring_ovw_i | input | 1 | Receive ring overwrite |
| evt_rdma_done_i | input | 1 | Remote DMA finished |
| stop_cmd_i | input | 1 | Controller enters stopped state |
| start_cmd_i | input | 1 | Start command issued |
| pkt_removed_i | input | 1 | A frame was taken out of the ring |
| inc_align_i | input | 1 | Frame alignment error seen |
| inc_crc_i | input | 1 | CRC error seen |
| inc_miss_i | input | 1 | Frame missed |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, same cycle as `rd_en_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all 128 enable values against each single event source. A wrong bit position or a wrong AND/OR term shows up as a wrong `irq_o` for some pairs.

Several collisions are driven on purpose:
- an event arriving in the same cycle as its clear; a design that lets the clear win loses the event;
- stop and start arriving together; a design that lets the clear win leaves the stopped flag low;
- an increment in the cycle of a clearing read; a design that drops it reads back 0 instead of 1.

Each tally is driven past 255 and must hold there; a design without saturation wraps back to a small count. Each tally is also driven across 128 so that bit 5 rises. The bit must then fall after the read and must ignore a write of one.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
  // status bit positions (read by software and by the interrupt OR)
  localparam int BIT_RX_OK   = 0;
  localparam int BIT_TX_OK   = 1;
  localparam int BIT_RX_ERR  = 2;
  localparam int BIT_TX_ERR  = 3;
  localparam int BIT_OVW     = 4;
  localparam int BIT_CNT_OVF = 5;
  localparam int BIT_RDMA    = 6;
  localparam int BIT_STOPPED = 7;
  localparam int NUM_SRC     = 7;

  // register offsets
  localparam int OFS_STATUS = 0;
  localparam int OFS_ENABLE = 1;
  localparam int OFS_TALLY0 = 2;
  localparam int NUM_TALLY  = 3;
endpackage

// File: rtl/net_irq_w1c_bit.sv
module net_irq_w1c_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R3 / R6: a set beats a simultaneous clear
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R2: sticky while nothing acts on it
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/net_irq_tally.sv
module net_irq_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_o <= '0;
    else if (rd_clr_i)                  cnt_o <= inc_i ? CNT_ONE : '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_ONE;
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !inc_i) |=> cnt_o == '0);
  assert_read_keeps_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && inc_i) |=> cnt_o == CNT_ONE);
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i && inc_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + CNT_ONE);
endmodule

// File: rtl/net_irq_unit.sv
module net_irq_unit
  import net_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_rx_ok_i,
  input  logic              evt_tx_ok_i,
  input  logic              evt_rx_err_i,
  input  logic              evt_tx_err_i,
  input  logic              evt_ring_ovw_i,
  input  logic              evt_rdma_done_i,
  input  logic              stop_cmd_i,
  input  logic              start_cmd_i,
  input  logic              pkt_removed_i,
  input  logic              inc_align_i,
  input  logic              inc_crc_i,
  input  logic              inc_miss_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o
);
  localparam logic [7:0] ENABLE_RW = 8'h7F;

  logic [7:0]           status_q;
  logic [7:0]           enable_q;
  logic [NUM_SRC-1:0]   src_v;
  logic [NUM_TALLY-1:0] tally_inc;
  logic [NUM_TALLY-1:0] tally_msb;
  logic [CNT_W-1:0]     tally_cnt [NUM_TALLY];
  logic                 wr_status;

  assign wr_status = wr_en_i && (addr_i == ADDR_W'(OFS_STATUS));
  assign tally_inc = {inc_miss_i, inc_crc_i, inc_align_i};

  assign src_v[BIT_RX_OK]   = evt_rx_ok_i;
  assign src_v[BIT_TX_OK]   = evt_tx_ok_i;
  assign src_v[BIT_RX_ERR]  = evt_rx_err_i;
  assign src_v[BIT_TX_ERR]  = evt_tx_err_i;
  assign src_v[BIT_OVW]     = evt_ring_ovw_i;
  assign src_v[BIT_CNT_OVF] = |tally_msb;
  assign src_v[BIT_RDMA]    = evt_rdma_done_i;

  // tally counters
  for (genvar t = 0; t < NUM_TALLY; t++) begin : g_tally
    net_irq_tally #(.CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (tally_inc[t]),
      .rd_clr_i(rd_en_i && (addr_i == ADDR_W'(OFS_TALLY0 + t))),
      .cnt_o   (tally_cnt[t])
    );
    assign tally_msb[t] = tally_cnt[t][CNT_W-1];
  end

  // status bits 0..6: latched sources, except the derived overflow bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    if (i == BIT_CNT_OVF) begin : g_derived
      assign status_q[i] = src_v[i];
    end else begin : g_latched
      net_irq_w1c_bit #(.RST_VAL(1'b0)) u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(src_v[i]),
        .clr_i(wr_status && wr_data_i[i]),
        .q_o  (status_q[i])
      );
    end
  end

  // stopped flag: state driven, not software writable
  net_irq_w1c_bit #(.RST_VAL(1'b1)) u_stopped (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(stop_cmd_i || evt_ring_ovw_i),
    .clr_i(start_cmd_i || pkt_removed_i),
    .q_o  (status_q[BIT_STOPPED])
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      enable_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(OFS_ENABLE))
      enable_q <= wr_data_i & ENABLE_RW;
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(OFS_STATUS))      rd_data_o = status_q;
    else if (addr_i == ADDR_W'(OFS_ENABLE)) rd_data_o = enable_q;
    else begin
      for (int t = 0; t < NUM_TALLY; t++)
        if (addr_i == ADDR_W'(OFS_TALLY0 + t)) rd_data_o = 8'(tally_cnt[t]);
    end
  end

  assign irq_o = |(status_q[NUM_SRC-1:0] & enable_q[NUM_SRC-1:0]);

  assert_enable_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(OFS_ENABLE)) |-> !rd_data_o[7]);
  assert_all_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFS_ENABLE) && wr_data_i == 8'h00) |=> !irq_o);
  assert_stop_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd_i || evt_ring_ovw_i) |=> status_q[BIT_STOPPED]);
  assert_stopped_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !stop_cmd_i && !evt_ring_ovw_i && !start_cmd_i && !pkt_removed_i)
      |=> $stable(status_q[BIT_STOPPED]));
endmodule

// File: tb/net_irq_unit_bench.sv
`timescale 1ns/100ps
module net_irq_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_rx_ok = 0, evt_tx_ok = 0, evt_rx_err = 0, evt_tx_err = 0;
  logic evt_ovw = 0, evt_rdma = 0, stop_cmd = 0, start_cmd = 0, pkt_removed = 0;
  logic inc_align = 0, inc_crc = 0, inc_miss = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  net_irq_unit u_net_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .evt_rx_ok_i(evt_rx_ok), .evt_tx_ok_i(evt_tx_ok),
    .evt_rx_err_i(evt_rx_err), .evt_tx_err_i(evt_tx_err),
    .evt_ring_ovw_i(evt_ovw), .evt_rdma_done_i(evt_rdma),
    .stop_cmd_i(stop_cmd), .start_cmd_i(start_cmd), .pkt_removed_i(pkt_removed),
    .inc_align_i(inc_align), .inc_crc_i(inc_crc), .inc_miss_i(inc_miss),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_all();
    evt_rx_ok = 0; evt_tx_ok = 0; evt_rx_err = 0; evt_tx_err = 0;
    evt_ovw = 0; evt_rdma = 0; stop_cmd = 0; start_cmd = 0; pkt_removed = 0;
    inc_align = 0; inc_crc = 0; inc_miss = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; addr = 3'(a); wr_data = 8'(d);
    step();
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_en = 1; addr = 3'(a);
    #1 v = int'(rd_data);
    step();
    rd_en = 0;
  endtask

  // src: 0 rx_ok,1 tx_ok,2 rx_err,3 tx_err,4 ovw,6 rdma,8 stop,9 start,10 removed,
  //      11 align,12 crc,13 miss
  task automatic set_src(input int s);
    case (s)
      0: evt_rx_ok = 1;   1: evt_tx_ok = 1;   2: evt_rx_err = 1;
      3: evt_tx_err = 1;  4: evt_ovw = 1;     6: evt_rdma = 1;
      8: stop_cmd = 1;    9: start_cmd = 1;   10: pkt_removed = 1;
      11: inc_align = 1;  12: inc_crc = 1;    13: inc_miss = 1;
      default: ;
    endcase
  endtask

  task automatic pulse(input int s);
    set_src(s);
    step();
    idle_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) step();
    rst_n = 1;
    step();

    // R1 reset state
    rd(0, v); check("R1 status", v, 8'h80);
    rd(1, v); check("R1 enable", v, 8'h00);
    for (int t = 0; t < 3; t++) begin rd(2 + t, v); check("R1 tally", v, 0); end
    #1 check("R1 irq", int'(irq), 0);

    // R4 enable bit 7 reserved
    wr(1, 8'hFF); rd(1, v); check("R4 enable readback", v, 8'h7F);
    wr(1, 8'h00);

    // R6 stopped flag
    pulse(9); rd(0, v); check("R6 start clears", v, 8'h00);
    pulse(8); rd(0, v); check("R6 stop sets", v, 8'h80);
    wr(0, 8'hFF); rd(0, v); check("R6 write cannot clear", v, 8'h80);
    pulse(9); rd(0, v); check("R6 start clears again", v, 8'h00);
    pulse(4); rd(0, v); check("R6 overwrite sets", v, 8'h90);
    wr(0, 8'h10); rd(0, v); check("R6 after ovw clear", v, 8'h80);
    pulse(10); rd(0, v); check("R6 removal clears", v, 8'h00);
    set_src(8); set_src(9); step(); idle_all();
    rd(0, v); check("R6 set wins", v, 8'h80);
    pulse(9);

    // R2 / R5 sweep of every source against every enable value
    for (int b = 0; b < 7; b++) begin
      if (b == 5) continue;
      pulse(b);
      rd(0, v); check("R2 event sets bit", v, (1 << b) | (b == 4 ? 8'h80 : 0));
      for (int m = 0; m < 128; m++) begin
        wr(1, m);
        #1 check("R5 irq sweep", int'(irq), ((m & (1 << b)) != 0) ? 1 : 0);
      end
      wr(0, 1 << b);
      rd(0, v); check("R3 clear one bit", v, (b == 4 ? 8'h80 : 0));
      if (b == 4) pulse(10);
    end
    wr(1, 8'h00);

    // R3 zeros leave bits, selective clear, event beats clear
    for (int b = 0; b < 7; b++) if (b != 5) set_src(b);
    step(); idle_all(); pulse(10);
    rd(0, v); check("R2 all sources", v, 8'h5F);
    wr(0, 8'h00); rd(0, v); check("R3 zero write holds", v, 8'h5F);
    wr(0, 8'h05); rd(0, v); check("R3 selective clear", v, 8'h5A);
    evt_rx_ok = 1; wr(0, 8'h01); idle_all();
    rd(0, v); check("R3 event beats clear", v, 8'h5B);
    wr(0, 8'h5F); rd(0, v); check("R3 clear all", v, 8'h00);

    // R7 / R8 / R9 tallies
    wr(1, 8'h20);
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 127; k++) pulse(11 + t);
      rd(0, v); check("R9 below msb", v, 0);
      pulse(11 + t);
      rd(0, v); check("R9 msb sets overflow", v, 8'h20);
      #1 check("R9 overflow irq", int'(irq), 1);
      wr(0, 8'h20); rd(0, v); check("R9 write ignored", v, 8'h20);
      rd(2 + t, v); check("R7 count 128", v, 128);
      rd(0, v); check("R9 clears after read", v, 0);
      rd(2 + t, v); check("R8 read cleared", v, 0);
      for (int k = 0; k < 260; k++) pulse(11 + t);
      rd(2 + t, v); check("R7 saturate", v, 255);
      set_src(11 + t); rd(2 + t, v); idle_all();
      check("R8 read with inc value", v, 0);
      rd(2 + t, v); check("R8 inc kept", v, 1);
    end
    wr(1, 8'h00);

    // R10 unused offsets
    for (int a = 5; a < 8; a++) begin rd(a, v); check("R10 unused", v, 0); end

    finish_run();
  end
endmodule